// File: doc/BRIEF.md
# Precision Local Time Counter

This block keeps the local time of a timing node as a 32-bit seconds count and a 30-bit nanoseconds count. A fixed-rate reference clock drives it. Each enabled cycle adds a nominal number of nanoseconds, and a signed fractional trim refines that amount so that software can steer the frequency. Software drives the block through a small bus of 16-bit registers. A command register starts or stops the counter, loads an absolute time, latches a coherent snapshot for reading, and steps the time by a bounded number of seconds or by a number of nanoseconds. The live time is also driven out on dedicated outputs for neighbouring timestamp logic.

Register map (address: content): 0 command, write only, reads 0; 1/2 load seconds high/low; 3/4 load nanoseconds high (bits 13:0)/low; 5/6 snapshot seconds high/low; 7/8 snapshot nanoseconds high/low, read only; 9/10 step value high/low; 11/12 trim high/low. In registers 9 and 11, bit 15 is a direction flag and bits 13:0 are magnitude bits 29:16.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time is 0 s 0 ns, the counter is stopped, and every register reads 0.
- R2: A write to addresses 1, 2, 3, 4, 9, 10, 11 or 12 is read back from the same address. The load-nanoseconds high register keeps only bits 13:0. Address 0 always reads 0, because command bits act for the write cycle only.
- R3: Command bit 1 starts the counter and bit 0 stops it, and stop wins when both are set. The change applies from the next cycle. While the counter is stopped the time holds and step commands have no effect.
- R4: With a zero trim, each cycle of a running counter adds NS_INC nanoseconds (8 by default).
- R5: Nanoseconds stay below 1,000,000,000. Reaching that value subtracts it and adds one to seconds.
- R6: Command bit 4 copies the load registers into the live time, whether the counter runs or not. A loaded nanoseconds value of 1,000,000,000 or more is reduced by 1,000,000,000 and adds one second.
- R7: Command bit 3 copies the live time, as it stood before that clock edge, into the snapshot registers. This works whether the counter runs or not.
- R8: Command bit 5 moves seconds by the step value, clamped to at most 15. Direction bit 15 of address 9 set means add and clear means subtract.
- R9: Command bit 6 adds the 30-bit step value to nanoseconds whatever the direction bit holds, and carries up to two seconds.
- R10: When the load bit is set together with a step bit, only the load takes effect.
- R11: The trim magnitude (2^-32 ns units) accumulates every running cycle. Each overflow of the fraction adds one nanosecond when bit 15 of address 11 is set, and each underflow withholds one when it is clear. A magnitude of 2^29 gives 65 ns per 8 cycles when positive and 63 ns when negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| sec_o | output | 32 | Live seconds |
| ns_o | output | 30 | Live nanoseconds |

## Verification
The hardest case to reach is a nanoseconds step that carries two seconds at once. The sum must pass 2,000,000,000, and that happens only when the live nanoseconds sit just below the wrap point at the moment the step lands. The stimulus loads 999,999,960 ns and issues a step of 1,000,000,050 ns in the very next cycle, which gives an exact, known sum. The trim is checked over windows of exactly eight cycles between two snapshots, so the expected difference does not depend on where the fractional accumulator stood.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;
  localparam int unsigned SEC_W = 32;
  localparam int unsigned NS_W = 30;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned SEC_STEP_MAX = 15;
  localparam int unsigned DIR_BIT = 15;

  localparam int unsigned C_DIS = 0;
  localparam int unsigned C_EN = 1;
  localparam int unsigned C_SNAP = 3;
  localparam int unsigned C_LOAD = 4;
  localparam int unsigned C_STEP_S = 5;
  localparam int unsigned C_STEP_N = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_CMD = 4'd0,
    A_SET_SH = 4'd1, A_SET_SL = 4'd2, A_SET_NH = 4'd3, A_SET_NL = 4'd4,
    A_RD_SH = 4'd5, A_RD_SL = 4'd6, A_RD_NH = 4'd7, A_RD_NL = 4'd8,
    A_STEP_H = 4'd9, A_STEP_L = 4'd10, A_TRIM_H = 4'd11, A_TRIM_L = 4'd12
  } reg_addr_e;

  typedef struct packed {
    logic dis;
    logic en;
    logic snap;
    logic load;
    logic step_s;
    logic step_n;
  } cmd_t;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [SEC_W-1:0]  live_sec_i,
  input  logic [NS_W-1:0]   live_ns_i,
  output cmd_t              cmd_o,
  output logic [SEC_W-1:0]  set_sec_o,
  output logic [NS_W-1:0]   set_ns_o,
  output logic [NS_W-1:0]   step_mag_o,
  output logic              step_dir_o,
  output logic [NS_W-1:0]   trim_mag_o,
  output logic              trim_dir_o,
  output logic [15:0]       rdata_o
);
  localparam int unsigned HI_W = NS_W - 16;

  logic [SEC_W-1:0] set_sec_q, rd_sec_q;
  logic [NS_W-1:0]  set_ns_q, rd_ns_q, step_q, trim_q;
  logic             step_dir_q, trim_dir_q;
  logic             wr_cmd;

  assign wr_cmd = we_i && (addr_i == A_CMD);

  // command bits live only for the write cycle
  always_comb begin
    cmd_o        = '0;
    cmd_o.dis    = wr_cmd & wdata_i[C_DIS];
    cmd_o.en     = wr_cmd & wdata_i[C_EN];
    cmd_o.snap   = wr_cmd & wdata_i[C_SNAP];
    cmd_o.load   = wr_cmd & wdata_i[C_LOAD];
    cmd_o.step_s = wr_cmd & wdata_i[C_STEP_S];
    cmd_o.step_n = wr_cmd & wdata_i[C_STEP_N];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_sec_q  <= '0;
      set_ns_q   <= '0;
      step_q     <= '0;
      step_dir_q <= 1'b0;
      trim_q     <= '0;
      trim_dir_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_SET_SH: set_sec_q[31:16] <= wdata_i;
        A_SET_SL: set_sec_q[15:0]  <= wdata_i;
        A_SET_NH: set_ns_q[NS_W-1:16] <= wdata_i[HI_W-1:0];
        A_SET_NL: set_ns_q[15:0]   <= wdata_i;
        A_STEP_H: begin
          step_q[NS_W-1:16] <= wdata_i[HI_W-1:0];
          step_dir_q        <= wdata_i[DIR_BIT];
        end
        A_STEP_L: step_q[15:0] <= wdata_i;
        A_TRIM_H: begin
          trim_q[NS_W-1:16] <= wdata_i[HI_W-1:0];
          trim_dir_q        <= wdata_i[DIR_BIT];
        end
        A_TRIM_L: trim_q[15:0] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sec_q <= '0;
      rd_ns_q  <= '0;
    end else if (cmd_o.snap) begin
      rd_sec_q <= live_sec_i;
      rd_ns_q  <= live_ns_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_SET_SH: rdata_o = set_sec_q[31:16];
      A_SET_SL: rdata_o = set_sec_q[15:0];
      A_SET_NH: rdata_o = 16'(set_ns_q[NS_W-1:16]);
      A_SET_NL: rdata_o = set_ns_q[15:0];
      A_RD_SH:  rdata_o = rd_sec_q[31:16];
      A_RD_SL:  rdata_o = rd_sec_q[15:0];
      A_RD_NH:  rdata_o = 16'(rd_ns_q[NS_W-1:16]);
      A_RD_NL:  rdata_o = rd_ns_q[15:0];
      A_STEP_H: rdata_o = {step_dir_q, 1'b0, step_q[NS_W-1:16]};
      A_STEP_L: rdata_o = step_q[15:0];
      A_TRIM_H: rdata_o = {trim_dir_q, 1'b0, trim_q[NS_W-1:16]};
      A_TRIM_L: rdata_o = trim_q[15:0];
      default:  rdata_o = '0;
    endcase
  end

  assign set_sec_o  = set_sec_q;
  assign set_ns_o   = set_ns_q;
  assign step_mag_o = step_q;
  assign step_dir_o = step_dir_q;
  assign trim_mag_o = trim_q;
  assign trim_dir_o = trim_dir_q;
endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_INC = 8,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned INC_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NS_W-1:0]  trim_mag_i,
  input  logic             trim_dir_i,
  output logic [INC_W-1:0] inc_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   trim_ext, add_s, sub_s;
  logic              carry, borrow;

  assign trim_ext = {{(FRAC_W + 1 - NS_W){1'b0}}, trim_mag_i};
  assign add_s    = {1'b0, frac_q} + trim_ext;
  assign sub_s    = {1'b0, frac_q} - trim_ext;
  assign carry    = trim_dir_i & add_s[FRAC_W];
  assign borrow   = ~trim_dir_i & sub_s[FRAC_W];
  assign inc_o    = INC_W'(NS_INC) + INC_W'(carry) - INC_W'(borrow);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frac_q <= '0;
    else if (tick_i) frac_q <= trim_dir_i ? add_s[FRAC_W-1:0] : sub_s[FRAC_W-1:0];
  end
endmodule

// File: rtl/ptp_tc_core.sv
module ptp_tc_core
  import ptp_tc_pkg::*;
#(
  parameter int unsigned INC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  input  logic [SEC_W-1:0] set_sec_i,
  input  logic [NS_W-1:0]  set_ns_i,
  input  logic [NS_W-1:0]  step_mag_i,
  input  logic             step_dir_i,
  input  logic [INC_W-1:0] inc_i,
  output logic             en_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  localparam logic [31:0] ONE_S = 32'(NS_PER_SEC);
  localparam logic [31:0] TWO_S = 32'(2 * NS_PER_SEC);

  logic             en_q;
  logic [SEC_W-1:0] sec_q, sec_adv, sec_ld, sec_delta;
  logic [NS_W-1:0]  ns_q, ns_adv, ns_ld;
  logic [31:0]      ns_sum, ns_red;
  logic [1:0]       carry;
  logic [3:0]       sec_mag;
  logic             ld_wrap;

  assign ns_sum = 32'(ns_q) + 32'(inc_i) + (cmd_i.step_n ? 32'(step_mag_i) : 32'd0);

  always_comb begin
    if (ns_sum >= TWO_S) begin
      ns_red = ns_sum - TWO_S;
      carry  = 2'd2;
    end else if (ns_sum >= ONE_S) begin
      ns_red = ns_sum - ONE_S;
      carry  = 2'd1;
    end else begin
      ns_red = ns_sum;
      carry  = 2'd0;
    end
  end
  assign ns_adv = ns_red[NS_W-1:0];

  // seconds step is bounded per command
  assign sec_mag   = (step_mag_i > NS_W'(SEC_STEP_MAX)) ? 4'(SEC_STEP_MAX) : step_mag_i[3:0];
  assign sec_delta = !cmd_i.step_s ? '0 :
                     step_dir_i    ? SEC_W'(sec_mag) : (~SEC_W'(sec_mag) + 1'b1);
  assign sec_adv   = sec_q + SEC_W'(carry) + sec_delta;

  assign ld_wrap = 32'(set_ns_i) >= ONE_S;
  assign ns_ld   = ld_wrap ? NS_W'(32'(set_ns_i) - ONE_S) : set_ns_i;
  assign sec_ld  = set_sec_i + SEC_W'(ld_wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (cmd_i.load) begin
      sec_q <= sec_ld;
      ns_q  <= ns_ld;
    end else if (en_q) begin
      sec_q <= sec_adv;
      ns_q  <= ns_adv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (cmd_i.dis) en_q <= 1'b0;
    else if (cmd_i.en)  en_q <= 1'b1;
  end

  assign en_o  = en_q;
  assign sec_o = sec_q;
  assign ns_o  = ns_q;
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_INC = 8,
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam int unsigned INC_W = $clog2(NS_INC + 2) + 1;

  cmd_t             cmd;
  logic [SEC_W-1:0] set_sec;
  logic [NS_W-1:0]  set_ns, step_mag, trim_mag;
  logic             step_dir, trim_dir, en_q;
  logic [INC_W-1:0] inc;

  ptp_tc_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .live_sec_i (sec_o),
    .live_ns_i  (ns_o),
    .cmd_o      (cmd),
    .set_sec_o  (set_sec),
    .set_ns_o   (set_ns),
    .step_mag_o (step_mag),
    .step_dir_o (step_dir),
    .trim_mag_o (trim_mag),
    .trim_dir_o (trim_dir),
    .rdata_o
  );

  ptp_tc_rate #(.NS_INC(NS_INC), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_rate (
    .clk_i, .rst_ni,
    .tick_i     (en_q),
    .trim_mag_i (trim_mag),
    .trim_dir_i (trim_dir),
    .inc_o      (inc)
  );

  ptp_tc_core #(.INC_W(INC_W)) u_core (
    .clk_i, .rst_ni,
    .cmd_i      (cmd),
    .set_sec_i  (set_sec),
    .set_ns_i   (set_ns),
    .step_mag_i (step_mag),
    .step_dir_i (step_dir),
    .inc_i      (inc),
    .en_o       (en_q),
    .sec_o,
    .ns_o
  );
endmodule

// File: rtl/ptp_tc_checker.sv
module ptp_tc_checker
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_INC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input cmd_t             cmd_i,
  input logic [SEC_W-1:0] sec_i,
  input logic [NS_W-1:0]  ns_i,
  input logic [SEC_W-1:0] set_sec_i,
  input logic [NS_W-1:0]  set_ns_i,
  input logic [NS_W-1:0]  trim_i
);
  localparam logic [31:0] ONE_S = 32'(NS_PER_SEC);
  logic quiet;
  assign quiet = (cmd_i == '0) && (trim_i == '0) && en_i;

  a_r5_ns_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ns_i) < ONE_S);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cmd_i.load) |=> ($stable(ns_i) && $stable(sec_i)));

  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.load && 32'(set_ns_i) < ONE_S) |=> (ns_i == $past(set_ns_i) && sec_i == $past(set_sec_i)));

  a_r4_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && 32'(ns_i) + NS_INC < ONE_S) |=> (32'(ns_i) == 32'($past(ns_i)) + NS_INC && $stable(sec_i)));

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && 32'(ns_i) + NS_INC >= ONE_S) |=> (sec_i == $past(sec_i) + 1'b1));
endmodule

bind ptp_time_counter ptp_tc_checker #(.NS_INC(NS_INC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_q),
  .cmd_i     (cmd),
  .sec_i     (sec_o),
  .ns_i      (ns_o),
  .set_sec_i (set_sec),
  .set_ns_i  (set_ns),
  .trim_i    (trim_mag)
);

// File: tb/tb_ptp_time_counter.sv
`timescale 1ns/1ps
module tb_ptp_time_counter;
  localparam longint unsigned NSEC = 64'd1_000_000_000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [31:0] sec_o;
  logic [29:0] ns_o;

  ptp_time_counter dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // requirement-level model of the time, valid while trim is zero
  longint unsigned m_total = 0, snap_total = 0;
  bit m_en = 0;
  logic [31:0] b_set_sec = '0;
  logic [29:0] b_set_ns = '0, b_step = '0;
  bit b_dir = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(logic [15:0] c);
    longint unsigned s, n, mag;
    if (c[3]) snap_total = m_total;
    if (c[4]) begin
      s = 64'(b_set_sec); n = 64'(b_set_ns);
      if (n >= NSEC) begin n -= NSEC; s++; end
      m_total = s * NSEC + n;
    end else if (m_en) begin
      m_total += 8;
      if (c[5]) begin
        mag = (b_step > 30'd15) ? 64'd15 : 64'(b_step);
        m_total = b_dir ? m_total + mag * NSEC : m_total - mag * NSEC;
      end
      if (c[6]) m_total += 64'(b_step);
    end
    if (c[0]) m_en = 0; else if (c[1]) m_en = 1;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    model_edge(a == 4'd0 ? d : 16'h0);
    case (a)
      4'd1:  b_set_sec[31:16] = d;
      4'd2:  b_set_sec[15:0] = d;
      4'd3:  b_set_ns[29:16] = d[13:0];
      4'd4:  b_set_ns[15:0] = d;
      4'd9:  begin b_step[29:16] = d[13:0]; b_dir = d[15]; end
      4'd10: b_step[15:0] = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] e, string tag);
    item_t it;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    model_edge(16'h0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      we_i = 1'b0;
      model_edge(16'h0);
    end
  endtask

  task automatic read_snap(string tag);
    longint unsigned s, n;
    s = snap_total / NSEC; n = snap_total % NSEC;
    rd(4'd5, s[31:16], tag);
    rd(4'd6, s[15:0], tag);
    rd(4'd7, {2'b0, n[29:16]}, tag);
    rd(4'd8, n[15:0], tag);
  endtask

  task automatic rd_val(logic [3:0] a, output logic [15:0] v);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    #2 v = rdata_o;
  endtask

  task automatic snap_time(output longint unsigned t);
    logic [15:0] sh, sl, nh, nl;
    rd_val(4'd5, sh); rd_val(4'd6, sl); rd_val(4'd7, nh); rd_val(4'd8, nl);
    t = 64'({sh, sl}) * NSEC + 64'({nh[13:0], nl});
  endtask

  // scoreboard monitor
  always begin
    item_t it;
    @(posedge clk_i);
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(rdata_o === it.exp, it.tag, 64'(rdata_o), 64'(it.exp));
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint unsigned t1, t2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 13; a++) rd(4'(a), 16'h0, "R1 reset register");

    // R2 readback, nanoseconds high keeps 14 bits, command reads 0
    wr(4'd3, 16'hFFFF);
    rd(4'd3, 16'h3FFF, "R2 ns high width");
    wr(4'd1, 16'h0001); wr(4'd2, 16'h0005);
    wr(4'd3, 16'h3B9A); wr(4'd4, 16'hC9D8);
    rd(4'd1, 16'h0001, "R2 set sec hi");
    rd(4'd2, 16'h0005, "R2 set sec lo");
    rd(4'd3, 16'h3B9A, "R2 set ns hi");
    rd(4'd4, 16'hC9D8, "R2 set ns lo");
    wr(4'd0, 16'h0000);
    rd(4'd0, 16'h0000, "R2 command self-clear");

    // R7 snapshot while stopped, R3 hold
    idle(5);
    wr(4'd0, 16'h0008); read_snap("R7 snapshot stopped");

    // R6 load while stopped
    wr(4'd0, 16'h0010); wr(4'd0, 16'h0008); read_snap("R6 load stopped");
    idle(3);
    wr(4'd0, 16'h0008); read_snap("R3 hold while stopped");

    // R3 step ignored while stopped
    wr(4'd9, 16'h8000); wr(4'd10, 16'h0005);
    rd(4'd9, 16'h8000, "R2 step hi");
    wr(4'd0, 16'h0020); wr(4'd0, 16'h0040);
    wr(4'd0, 16'h0008); read_snap("R3 step ignored stopped");

    // R4 ticking, R5 wrap
    wr(4'd0, 16'h0002);
    wr(4'd0, 16'h0008); read_snap("R4 tick start");
    wr(4'd0, 16'h0008); read_snap("R5 wrap into seconds");
    idle(4);
    wr(4'd0, 16'h0008); read_snap("R4 tick run");

    // R8 seconds step add, then clamp and subtract
    wr(4'd0, 16'h0020);
    wr(4'd0, 16'h0008); read_snap("R8 seconds add");
    wr(4'd9, 16'h0000); wr(4'd10, 16'h0064);
    wr(4'd0, 16'h0020);
    wr(4'd0, 16'h0008); read_snap("R8 seconds clamp subtract");

    // R9 nanoseconds step with double carry, direction clear
    wr(4'd9, 16'h3B9A); wr(4'd10, 16'hCA32);
    wr(4'd0, 16'h0010);
    wr(4'd0, 16'h0040);
    wr(4'd0, 16'h0008); read_snap("R9 ns step double carry");

    // R10 load wins over seconds step
    wr(4'd9, 16'h8000); wr(4'd10, 16'h0003);
    wr(4'd0, 16'h0030);
    wr(4'd0, 16'h0008); read_snap("R10 load priority");

    // R6 oversize nanoseconds normalised on load
    wr(4'd3, 16'h3FFF); wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'h0010);
    wr(4'd0, 16'h0008); read_snap("R6 load normalise");

    // R3 stop wins over start
    wr(4'd0, 16'h0003);
    wr(4'd0, 16'h0008); read_snap("R3 stop wins");
    idle(4);
    wr(4'd0, 16'h0008); read_snap("R3 stopped stays");

    // R11 trim, positive then negative, 8-cycle windows
    wr(4'd0, 16'h0002);
    wr(4'd11, 16'hA000); wr(4'd12, 16'h0000);
    rd(4'd11, 16'hA000, "R11 trim readback");
    idle(2);
    wr(4'd0, 16'h0008); snap_time(t1); idle(3);
    wr(4'd0, 16'h0008); snap_time(t2);
    chk(t2 - t1 == 65, "R11 positive trim", longint'(t2 - t1), 65);
    wr(4'd11, 16'h2000);
    idle(2);
    wr(4'd0, 16'h0008); snap_time(t1); idle(3);
    wr(4'd0, 16'h0008); snap_time(t2);
    chk(t2 - t1 == 63, "R11 negative trim", longint'(t2 - t1), 63);

    idle(3);
    wait (q.size() == 0);
    idle(1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule